// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps the books for a packet memory cut into 256-byte pages inside a network controller. Packets are known by small packet numbers. Each number is a slot that records how many pages the packet holds. The packet RAM and the data ports that fill it are outside the block. Here only the page and slot accounting and the three packet-number queues are kept.

A host writes 8-bit command codes. With them it can allocate a run of pages for a packet it is about to transmit, hand an allocated packet to the transmit queue, drop or free the oldest received packet, flush the transmit queues, or return the whole memory to its empty state. The receive MAC asks for pages directly, and each packet it gets is appended to the receive queue. The transmit MAC takes packets from the head of the transmit queue and reports when each one completes. A completed packet is either freed at once or parked in a transmit-done queue, depending on the auto-free setting. The host reads a busy flag, an allocation result byte, a memory-information word and a packed queue-status word.

Top module: `pkt_mmu`

## Requirements
- R1: After reset, busy is 0, alloc_result is 0x80, mem_info reports TOTAL_PAGES in both bytes (0x1010 at the default of 16 pages) and queue_status is 0x8080.
- R2: The command class is taken from cmd_code[7:5]: 001 allocate (cmd_code[2:0] holds pages minus one), 010 reset everything, 100 drop the receive head, 101 free the receive head, 110 enqueue cur_pkt, 111 flush the transmit queues. Classes 000 and 011 change no state.
- R3: An accepted command (cmd_valid while busy is 0) raises busy in the next cycle, and busy stays high for CMD_LAT cycles. Commands presented while busy is high are ignored.
- R4: When an allocate command is accepted, alloc_result becomes 0x80. As soon as a free slot and enough free pages exist, the lowest free slot number is placed in alloc_result[6:0] with bit 7 clear. The free page count drops by the requested amount, and alloc_done pulses for one cycle. The earliest this can happen is one cycle after acceptance.
- R5: An allocation that cannot be met stays pending, with alloc_result at 0x80 and no alloc_done. It completes by itself once enough pages have been returned.
- R6: mem_info[7:0] is the total page count and mem_info[15:8] is the free page count.
- R7: queue_status[6:0] is the transmit-done head and queue_status[7] is set when that queue is empty. queue_status[14:8] is the receive head and queue_status[15] is set when that queue is empty. A head field reads zero while its queue is empty.
- R8: A receive request (rx_req with rx_pages = pages minus one) takes the lowest free slot and appends it to the receive queue. If no slot, not enough pages or no queue space is available, nothing is allocated and rx_drop pulses for one cycle.
- R9: Drop-head removes the receive head and leaves its pages allocated. Free-head removes the receive head and returns its pages to the free pool.
- R10: Enqueue appends cur_pkt to the transmit queue. tx_head_valid and tx_head_pkt present the oldest queued packet.
- R11: A tx_done pulse removes the transmit head. If auto_release and tx_ok are both high, that packet's pages are freed. Otherwise the packet number is appended to the transmit-done queue.
- R12: Flush-transmit empties the transmit and transmit-done queues and leaves every page allocated.
- R13: Reset-everything returns all pages, empties all three queues and cancels a pending allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cur_pkt | input | 7 | Packet number used by enqueue |
| auto_release | input | 1 | Free packets that transmit successfully |
| busy | output | 1 | Command in progress |
| alloc_result | output | 8 | Bit 7 set for fail/pending, else packet number |
| alloc_done | output | 1 | One-cycle pulse when a host allocation completes |
| mem_info | output | 16 | {free pages, total pages} |
| queue_status | output | 16 | {rx empty, rx head, done empty, done head} |
| rx_req | input | 1 | Receive MAC page request |
| rx_pages | input | 3 | Requested pages minus one |
| rx_drop | output | 1 | One-cycle pulse when a receive request is refused |
| tx_head_valid | output | 1 | Transmit queue not empty |
| tx_head_pkt | output | 7 | Oldest packet queued for transmit |
| tx_done | input | 1 | Transmit head finished |
| tx_ok | input | 1 | Finished transmission succeeded |

## Verification
The hardest state to reach is an allocation left pending that later finishes without any further host command. To get there, the stimulus first uses up most of the pages. It then asks for more than remain and checks that the result stays at 0x80 with no done pulse. Finally it pushes a large packet through the transmit queue with auto-free set, so that the completion returns the pages and the stalled request is granted the slot that was just freed. A second hard case is a pending request at the moment of a full reset. The bench sets this up and then confirms that the free count stays at the total afterwards.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    typedef enum logic [2:0] {
        OP_IDLE0     = 3'd0,
        OP_ALLOC     = 3'd1,
        OP_WIPE      = 3'd2,
        OP_IDLE3     = 3'd3,
        OP_RX_DROP   = 3'd4,
        OP_RX_FREE   = 3'd5,
        OP_TX_PUSH   = 3'd6,
        OP_TX_FLUSH  = 3'd7
    } mmu_op_e;

    localparam int          FIELD_W     = 7;
    localparam logic [7:0]  RESULT_FAIL = 8'h80;
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [AW:0]             cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == (AW+1)'(DEPTH));
    assign head  = q.mem[q.rd];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wr] = push_data;
                d.wr        = (q.wr == AW'(DEPTH-1)) ? '0 : q.wr + 1'b1;
            end
            if (do_pop) begin
                d.rd = (q.rd == AW'(DEPTH-1)) ? '0 : q.rd + 1'b1;
            end
            d.cnt = q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/slot_finder.sv
module slot_finder #(
    parameter int NUM = 8,
    parameter int PW  = 3
) (
    input  logic [NUM-1:0] used,
    output logic           found,
    output logic [PW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM-1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/pkt_mmu.sv
module pkt_mmu
    import mmu_pkg::*;
#(
    parameter int TOTAL_PAGES = 16,
    parameter int NUM_PKTS    = 8,
    parameter int ALLOC_BITS  = 3,
    parameter int CMD_LAT     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_code,
    input  logic [6:0]  cur_pkt,
    input  logic        auto_release,
    output logic        busy,
    output logic [7:0]  alloc_result,
    output logic        alloc_done,
    output logic [15:0] mem_info,
    output logic [15:0] queue_status,
    input  logic        rx_req,
    input  logic [2:0]  rx_pages,
    output logic        rx_drop,
    output logic        tx_head_valid,
    output logic [6:0]  tx_head_pkt,
    input  logic        tx_done,
    input  logic        tx_ok
);
    localparam int PW = $clog2(NUM_PKTS);
    localparam int NW = ALLOC_BITS + 1;
    localparam int CW = $clog2(CMD_LAT + 1);

    typedef struct packed {
        logic [CW-1:0]                busy_cnt;
        logic                         pend;
        logic [NW-1:0]                pend_pages;
        logic [7:0]                   result;
        logic                         done;
        logic                         drop;
        logic [7:0]                   free_pages;
        logic [NUM_PKTS-1:0]          used;
        logic [NUM_PKTS-1:0][NW-1:0]  pages;
    } mmu_t;

    mmu_t q, d;

    // queue wiring
    logic          rx_push, rx_pop, rx_flush, rx_empty, rx_full;
    logic [PW-1:0] rx_head, rx_wdata;
    logic          tx_push, tx_pop, tx_flush, tx_empty, tx_full;
    logic [PW-1:0] tx_head;
    logic          dn_push, dn_pop, dn_flush, dn_empty, dn_full;
    logic [PW-1:0] dn_head;
    logic          slot_found;
    logic [PW-1:0] slot_idx;

    logic          accept;
    mmu_op_e       op;
    logic [NW-1:0] cmd_need, rx_need;
    logic [7:0]    freed, taken;

    logic unused_bits;
    assign unused_bits = ^{cmd_code[4:ALLOC_BITS], cur_pkt[6:PW], dn_full};

    assign accept   = cmd_valid && (q.busy_cnt == '0);
    assign op       = mmu_op_e'(cmd_code[7:5]);
    assign cmd_need = {1'b0, cmd_code[ALLOC_BITS-1:0]} + 1'b1;
    assign rx_need  = {1'b0, rx_pages} + 1'b1;
    assign dn_pop   = 1'b0;

    slot_finder #(.NUM(NUM_PKTS), .PW(PW)) u_find (
        .used  (q.used),
        .found (slot_found),
        .idx   (slot_idx)
    );

    pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
        .push_data(rx_wdata), .pop(rx_pop), .head(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
        .push_data(cur_pkt[PW-1:0]), .pop(tx_pop), .head(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) u_doneq (
        .clk(clk), .rst_n(rst_n), .flush(dn_flush), .push(dn_push),
        .push_data(tx_head), .pop(dn_pop), .head(dn_head),
        .empty(dn_empty), .full(dn_full)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.drop   = 1'b0;
        rx_push  = 1'b0;
        rx_pop   = 1'b0;
        rx_flush = 1'b0;
        rx_wdata = slot_idx;
        tx_push  = 1'b0;
        tx_pop   = 1'b0;
        tx_flush = 1'b0;
        dn_push  = 1'b0;
        dn_flush = 1'b0;
        freed    = '0;
        taken    = '0;

        if (q.busy_cnt != '0) d.busy_cnt = q.busy_cnt - 1'b1;
        if (accept)           d.busy_cnt = CW'(CMD_LAT);

        if (accept && op == OP_WIPE) begin
            d.used       = '0;
            d.free_pages = 8'(TOTAL_PAGES);
            d.pend       = 1'b0;
            rx_flush     = 1'b1;
            tx_flush     = 1'b1;
            dn_flush     = 1'b1;
        end else begin
            if (accept) begin
                case (op)
                    OP_ALLOC: begin
                        d.pend       = 1'b1;
                        d.pend_pages = cmd_need;
                        d.result     = RESULT_FAIL;
                    end
                    OP_RX_DROP: rx_pop = !rx_empty;
                    OP_RX_FREE: begin
                        if (!rx_empty) begin
                            rx_pop            = 1'b1;
                            d.used[rx_head]   = 1'b0;
                            freed             = freed + 8'(q.pages[rx_head]);
                        end
                    end
                    OP_TX_PUSH: tx_push = !tx_full;
                    OP_TX_FLUSH: begin
                        tx_flush = 1'b1;
                        dn_flush = 1'b1;
                    end
                    default: ;
                endcase
            end

            if (tx_done && !tx_empty && !tx_flush) begin
                tx_pop = 1'b1;
                if (auto_release && tx_ok) begin
                    d.used[tx_head] = 1'b0;
                    freed           = freed + 8'(q.pages[tx_head]);
                end else begin
                    dn_push = 1'b1;
                end
            end

            if (rx_req) begin
                if (slot_found && !rx_full && q.free_pages >= 8'(rx_need)) begin
                    d.used[slot_idx]  = 1'b1;
                    d.pages[slot_idx] = rx_need;
                    rx_push           = 1'b1;
                    taken             = 8'(rx_need);
                end else begin
                    d.drop = 1'b1;
                end
            end else if (q.pend && !(accept && op == OP_ALLOC) && slot_found &&
                         q.free_pages >= 8'(q.pend_pages)) begin
                d.used[slot_idx]  = 1'b1;
                d.pages[slot_idx] = q.pend_pages;
                d.pend            = 1'b0;
                d.done            = 1'b1;
                d.result          = 8'(slot_idx);
                taken             = 8'(q.pend_pages);
            end

            d.free_pages = q.free_pages + freed - taken;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.result     <= RESULT_FAIL;
            q.free_pages <= 8'(TOTAL_PAGES);
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.busy_cnt != '0);
    assign alloc_result  = q.result;
    assign alloc_done    = q.done;
    assign rx_drop       = q.drop;
    assign mem_info      = {q.free_pages, 8'(TOTAL_PAGES)};
    assign queue_status  = {rx_empty, rx_empty ? 7'd0 : FIELD_W'(rx_head),
                            dn_empty, dn_empty ? 7'd0 : FIELD_W'(dn_head)};
    assign tx_head_valid = !tx_empty;
    assign tx_head_pkt   = tx_empty ? 7'd0 : FIELD_W'(tx_head);
endmodule

// File: rtl/pkt_mmu_checker.sv
module pkt_mmu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [7:0]  cmd_code,
    input logic        busy,
    input logic [7:0]  alloc_result,
    input logic        alloc_done,
    input logic [15:0] mem_info,
    input logic [15:0] queue_status
);
    assert_busy_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    assert_free_within_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_info[15:8] <= mem_info[7:0]);

    assert_done_has_number_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |-> !alloc_result[7]);

    assert_wipe_restores_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_code[7:5] == 3'b010) |=>
        (mem_info[15:8] == mem_info[7:0] && queue_status[15] && queue_status[7]));

    assert_done_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |=> !alloc_done);
endmodule

bind pkt_mmu pkt_mmu_checker u_chk (.*);

// File: tb/pkt_mmu_test.sv
module pkt_mmu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [6:0]  cur_pkt = 7'd0;
    logic        auto_release = 1'b0;
    logic        rx_req = 1'b0;
    logic [2:0]  rx_pages = 3'd0;
    logic        tx_done = 1'b0;
    logic        tx_ok = 1'b0;
    logic        busy, alloc_done, rx_drop, tx_head_valid;
    logic [7:0]  alloc_result;
    logic [15:0] mem_info, queue_status;
    logic [6:0]  tx_head_pkt;

    int nchecks = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pkt_mmu uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cur_pkt(cur_pkt), .auto_release(auto_release), .busy(busy),
        .alloc_result(alloc_result), .alloc_done(alloc_done),
        .mem_info(mem_info), .queue_status(queue_status), .rx_req(rx_req),
        .rx_pages(rx_pages), .rx_drop(rx_drop), .tx_head_valid(tx_head_valid),
        .tx_head_pkt(tx_head_pkt), .tx_done(tx_done), .tx_ok(tx_ok)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic alloc_cmd(input logic [7:0] c, input logic ok, input logic [7:0] pkt, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({tag, " R3 busy after accept"}, 32'(busy), 32'd1);
        check({tag, " R4 result pending"}, 32'(alloc_result), 32'h80);
        @(negedge clk);
        check({tag, " R4/R5 done pulse"}, 32'(alloc_done), 32'(ok));
        check({tag, " R4/R5 result"}, 32'(alloc_result), ok ? 32'(pkt) : 32'h80);
        repeat (2) @(negedge clk);
        check({tag, " R3 busy released"}, 32'(busy), 32'd0);
    endtask

    task automatic finish_tx(input logic ok, input logic autof);
        @(negedge clk);
        tx_done = 1'b1;
        tx_ok = ok;
        auto_release = autof;
        @(negedge clk);
        tx_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_request(input logic [2:0] pm1, input logic exp_drop, input string tag);
        @(negedge clk);
        rx_req = 1'b1;
        rx_pages = pm1;
        @(negedge clk);
        rx_req = 1'b0;
        check({tag, " R8 rx_drop"}, 32'(rx_drop), 32'(exp_drop));
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 alloc_result", 32'(alloc_result), 32'h80);
        check("R1 R6 mem_info", 32'(mem_info), 32'h1010);
        check("R1 R7 queue_status", 32'(queue_status), 32'h8080);
    endtask

    task automatic t_alloc_basic;
        alloc_cmd(8'h21, 1'b1, 8'h00, "alloc2");
        check("R6 free after 2 pages", 32'(mem_info), 32'h0E10);
        alloc_cmd(8'h22, 1'b1, 8'h01, "alloc3");
        check("R6 free after 3 pages", 32'(mem_info), 32'h0B10);
    endtask

    task automatic t_tx_path;
        cur_pkt = 7'd0;
        send_cmd(8'hC0);
        check("R10 tx head valid", 32'(tx_head_valid), 32'd1);
        check("R10 tx head pkt", 32'(tx_head_pkt), 32'd0);
        finish_tx(1'b1, 1'b1);
        check("R11 auto free pages", 32'(mem_info), 32'h0D10);
        check("R11 tx queue empty", 32'(tx_head_valid), 32'd0);
        check("R11 R7 done queue empty", 32'(queue_status), 32'h8080);
        cur_pkt = 7'd1;
        send_cmd(8'hC0);
        finish_tx(1'b1, 1'b0);
        check("R11 R7 parked in done queue", 32'(queue_status), 32'h8001);
        check("R11 pages kept", 32'(mem_info), 32'h0D10);
    endtask

    task automatic t_tx_flush;
        send_cmd(8'hE0);
        check("R12 queues flushed", 32'(queue_status), 32'h8080);
        check("R12 pages kept", 32'(mem_info), 32'h0D10);
    endtask

    task automatic t_rx_path;
        rx_request(3'd1, 1'b0, "rx2");
        check("R8 R7 rx head slot0", 32'(queue_status), 32'h0080);
        check("R8 free", 32'(mem_info), 32'h0B10);
        rx_request(3'd3, 1'b0, "rx4");
        check("R8 free after second", 32'(mem_info), 32'h0710);
        send_cmd(8'h80);
        check("R9 drop head advances", 32'(queue_status), 32'h0280);
        check("R9 drop keeps pages", 32'(mem_info), 32'h0710);
        send_cmd(8'hA0);
        check("R9 free head empties", 32'(queue_status), 32'h8080);
        check("R9 free returns pages", 32'(mem_info), 32'h0B10);
    endtask

    task automatic t_pending;
        alloc_cmd(8'h27, 1'b1, 8'h02, "alloc8");
        check("R4 free after 8", 32'(mem_info), 32'h0310);
        alloc_cmd(8'h27, 1'b0, 8'h00, "alloc8 fails");
        repeat (3) @(negedge clk);
        check("R5 still pending", 32'(alloc_result), 32'h80);
        cur_pkt = 7'd2;
        send_cmd(8'hC0);
        finish_tx(1'b1, 1'b1);
        check("R5 pending completed", 32'(alloc_result), 32'h02);
        check("R5 pages retaken", 32'(mem_info), 32'h0310);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code = 8'h20;
        @(negedge clk);
        cmd_code = 8'h40;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 wipe while busy ignored", 32'(mem_info), 32'h0210);
        check("R4 one page slot3", 32'(alloc_result), 32'h03);
    endtask

    task automatic t_spare_code;
        send_cmd(8'h60);
        check("R2 spare code free", 32'(mem_info), 32'h0210);
        check("R2 spare code result", 32'(alloc_result), 32'h03);
        check("R2 spare code queues", 32'(queue_status), 32'h8080);
    endtask

    task automatic t_rx_drop;
        rx_request(3'd7, 1'b1, "rx too big");
        check("R8 refused leaves queue empty", 32'(queue_status), 32'h8080);
        check("R8 refused leaves pages", 32'(mem_info), 32'h0210);
    endtask

    task automatic t_wipe;
        rx_request(3'd0, 1'b0, "rx1");
        check("R8 rx head slot4", 32'(queue_status), 32'h0480);
        alloc_cmd(8'h27, 1'b0, 8'h00, "alloc8 pend");
        cur_pkt = 7'd3;
        send_cmd(8'hC0);
        check("R10 head before wipe", 32'(tx_head_valid), 32'd1);
        send_cmd(8'h40);
        check("R13 pages returned", 32'(mem_info), 32'h1010);
        check("R13 queues empty", 32'(queue_status), 32'h8080);
        check("R13 tx queue empty", 32'(tx_head_valid), 32'd0);
        repeat (5) @(negedge clk);
        check("R13 pending cancelled", 32'(mem_info), 32'h1010);
        check("R13 no late done", 32'(alloc_done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_alloc_basic();
        t_tx_path();
        t_tx_flush();
        t_rx_path();
        t_pending();
        t_busy_ignore();
        t_spare_code();
        t_rx_drop();
        t_wipe();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end
endmodule